// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Target Engine

This block is the bus-facing protocol engine of a 512-byte serial EEPROM model. It oversamples the two-wire clock and data lines with a fast system clock. It finds start, repeated start and stop conditions and shifts 8-bit words in and out, most significant bit first. It pulls the data line low through an output enable when it acknowledges or sends a zero, and it never drives the line high.

The engine does not hold the memory itself. It sends load and increment commands to an external address counter. It hands each accepted write byte to a page-write unit and tells that unit to start its internal write cycle when a stop arrives. Read data comes back from the memory at the counter's address. The page-write unit reports a busy level. While that level is high, the engine refuses to answer, so a controller can poll for the end of the write cycle.

Top module: `eeprom_i2c_target`

## Requirements
- R1: A start condition (data falls while clock is high) seen in any state abandons the transfer in progress and begins device-word reception from bit 7. A stop condition (data rises while clock is high) returns the engine to idle.
- R2: Incoming bits are taken on clock rising edges, most significant bit first. The engine changes `sda_oe_o` only while the clock is low, and it acknowledges by holding it high through the ninth clock.
- R3: The device word is acknowledged only when bits 7:4 equal 1010 and bits 3:2 equal {`pin_a2`,`pin_a1`}. On a mismatch the engine gives no acknowledge and stays released until the next start. After reset `sda_oe_o` is low.
- R4: In a write, the engine acknowledges the byte after the device word and pulses `addr_load_o` once with `addr_val_o` = {device-word bit 1, that byte}.
- R5: With `wp_i` low, each data byte is acknowledged and output on `wr_data_o` with a one-cycle `wr_strobe_o`. A stop after at least one accepted data byte gives exactly one `commit_start_o` pulse. A stop with no accepted data byte gives none.
- R6: With `wp_i` high, the device word and the address byte are still acknowledged. Every data byte gets a NACK, and no `wr_strobe_o` or `commit_start_o` is issued.
- R7: A matching device word with bit 0 = 1 is acknowledged. The engine then sends `rd_data_i` most significant bit first and pulses `addr_inc_o` once for every byte it loads for sending.
- R8: After each read byte the engine releases the data line and samples the controller's bit. A low bit starts the next byte. A high bit leaves the line released, with no further data, until a stop or start.
- R9: While `commit_busy_i` is high, a matching device word is answered with NACK whatever its read/write bit, and the engine returns to idle. Once the level drops, the same word is acknowledged.
- R10: A write of device word and address byte with no data, followed by a repeated start and a read device word, returns data starting at the address just loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| pin_a2 | input | 1 | Strap compared with device-word bit 3 |
| pin_a1 | input | 1 | Strap compared with device-word bit 2 |
| wp_i | input | 1 | Write protect, high refuses data bytes |
| commit_busy_i | input | 1 | Page-write unit is in its internal write cycle |
| rd_data_i | input | 8 | Memory byte at the counter's address |
| sda_oe_o | output | 1 | High pulls the data line low |
| addr_load_o | output | 1 | One-cycle load command to the address counter |
| addr_val_o | output | 9 | Address to load |
| addr_inc_o | output | 1 | One-cycle increment command after a read byte is taken |
| wr_strobe_o | output | 1 | One-cycle strobe for an accepted write byte |
| wr_data_o | output | 8 | Accepted write byte |
| commit_start_o | output | 1 | One-cycle start of the internal write cycle |

## Verification
The bench targets a start that arrives in the middle of a byte. A design that kept its bit count would misread the next device word and fail to acknowledge it. It writes with protection on and reads the bytes back. A design that acknowledged or stored the data, or committed it, shows a wrong acknowledge, extra strobes or altered memory. It checks page roll-over on write and array wrap on sequential read, so a wrong address hand-off gives wrong read data. It also gives a NACK without a stop and keeps clocking, where any pull on the line means the design kept sending. The bench also polls while busy.

// File: rtl/i2c_tgt_pkg.sv
// Shared types and constants for the two-wire EEPROM target engine.
package i2c_tgt_pkg;

    // Protocol sequencer states.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RD_ACK,
        ST_RD_WAIT
    } tgt_state_e;

    // Fixed device-type code carried in device-word bits 7:4.
    localparam logic [3:0] DEV_TYPE_CODE = 4'b1010;

endpackage

// File: rtl/i2c_line_sync.sv
// Line synchronizer and bus-event detector.
// Takes asynchronous clock/data line levels through STAGES flops.
// It keeps one extra sample and decodes clock edges and start/stop conditions.
// Assumes STAGES >= 2 and a system clock at least 8x the bus clock.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_d;
    logic              sda_d;

    // Synchronizer chains plus one history sample; the idle bus level is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
            scl_d  <= scl_ff[STAGES-1];
            sda_d  <= sda_ff[STAGES-1];
        end
    end

    assign scl_lvl   = scl_ff[STAGES-1];
    assign sda_lvl   = sda_ff[STAGES-1];
    assign scl_rise  = scl_lvl & ~scl_d;
    assign scl_fall  = ~scl_lvl & scl_d;
    assign start_det = scl_lvl & scl_d & sda_d & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_d & ~sda_d & sda_lvl;

endmodule

// File: rtl/i2c_tgt_fsm.sv
// Protocol sequencer for the EEPROM target.
// Shifts words in and out, decides acknowledges and issues one-cycle commands
// to the address counter and page-write unit.
// Assumes synchronized line levels and single-cycle edge/condition pulses.
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              pin_a2,
    input  logic              pin_a1,
    input  logic              wp_i,
    input  logic              busy_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              sda_oe,
    output logic              addr_load,
    output logic [ADDR_W-1:0] addr_val,
    output logic              rd_inc,
    output logic              wr_strobe,
    output logic [DATA_W-1:0] wr_data,
    output logic              commit_start
);

    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);

    tgt_state_e        state;
    logic [CNT_W-1:0]  bitcnt;
    logic [DATA_W-1:0] shreg;
    logic              hi_addr;
    logic              is_read;
    logic              got_data;
    logic              host_ack;
    logic              dev_match;

    // Device word matches type code and strap pins.
    assign dev_match = (shreg[DATA_W-1 -: 4] == DEV_TYPE_CODE) &&
                       (shreg[3:2] == {pin_a2, pin_a1});

    // Main sequencer: bus conditions first, then per-state bit handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            bitcnt       <= '0;
            shreg        <= '0;
            hi_addr      <= 1'b0;
            is_read      <= 1'b0;
            got_data     <= 1'b0;
            host_ack     <= 1'b0;
            sda_oe       <= 1'b0;
            addr_load    <= 1'b0;
            addr_val     <= '0;
            rd_inc       <= 1'b0;
            wr_strobe    <= 1'b0;
            wr_data      <= '0;
            commit_start <= 1'b0;
        end else begin
            addr_load    <= 1'b0;
            rd_inc       <= 1'b0;
            wr_strobe    <= 1'b0;
            commit_start <= 1'b0;
            if (start_det) begin
                state    <= ST_DEV;
                bitcnt   <= '0;
                sda_oe   <= 1'b0;
                got_data <= 1'b0;
            end else if (stop_det) begin
                commit_start <= got_data;
                got_data     <= 1'b0;
                state        <= ST_IDLE;
                sda_oe       <= 1'b0;
            end else begin
                case (state)
                    ST_DEV, ST_ADDR, ST_WDATA: begin
                        if (scl_rise && bitcnt != LAST_BIT) begin
                            shreg  <= {shreg[DATA_W-2:0], sda_lvl};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall && bitcnt == LAST_BIT) begin
                            bitcnt <= '0;
                            if (state == ST_DEV) begin
                                if (dev_match && !busy_i) begin
                                    sda_oe  <= 1'b1;
                                    is_read <= shreg[0];
                                    hi_addr <= shreg[1];
                                    state   <= ST_DEV_ACK;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else if (state == ST_ADDR) begin
                                sda_oe    <= 1'b1;
                                addr_load <= 1'b1;
                                addr_val  <= {hi_addr, shreg};
                                state     <= ST_ADDR_ACK;
                            end else begin
                                if (!wp_i) begin
                                    sda_oe    <= 1'b1;
                                    wr_strobe <= 1'b1;
                                    wr_data   <= shreg;
                                    got_data  <= 1'b1;
                                end
                                state <= ST_WDATA_ACK;
                            end
                        end
                    end
                    ST_DEV_ACK: begin
                        if (scl_fall) begin
                            if (is_read) begin
                                shreg  <= rd_data_i;
                                sda_oe <= ~rd_data_i[DATA_W-1];
                                rd_inc <= 1'b1;
                                state  <= ST_RDATA;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_ADDR;
                            end
                        end
                    end
                    ST_ADDR_ACK, ST_WDATA_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            state  <= ST_WDATA;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_rise) begin
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall) begin
                            if (bitcnt == LAST_BIT) begin
                                bitcnt <= '0;
                                sda_oe <= 1'b0;
                                state  <= ST_RD_ACK;
                            end else begin
                                shreg  <= shreg << 1;
                                sda_oe <= ~shreg[DATA_W-2];
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) begin
                            host_ack <= ~sda_lvl;
                        end else if (scl_fall) begin
                            if (host_ack) begin
                                shreg  <= rd_data_i;
                                sda_oe <= ~rd_data_i[DATA_W-1];
                                rd_inc <= 1'b1;
                                state  <= ST_RDATA;
                            end else begin
                                state <= ST_RD_WAIT;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R1
    start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_DEV && bitcnt == '0));

    // R2
    oe_low_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> $past(!scl_lvl));

    // R3
    idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);

    // R5
    commit_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_start |-> $past(stop_det));

    // R6
    no_write_protected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |-> $past(!wp_i));

    // R8
    nack_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_WAIT) |-> !sda_oe);

endmodule

// File: rtl/eeprom_i2c_target.sv
// Top of the two-wire EEPROM target engine.
// Joins the line synchronizer to the protocol sequencer.
// Assumes ADDR_W = DATA_W + 1: device-word bit 1 extends the address byte.
module eeprom_i2c_target #(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              pin_a2,
    input  logic              pin_a1,
    input  logic              wp_i,
    input  logic              commit_busy_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              sda_oe_o,
    output logic              addr_load_o,
    output logic [ADDR_W-1:0] addr_val_o,
    output logic              addr_inc_o,
    output logic              wr_strobe_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              commit_start_o
);

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_tgt_fsm #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_lvl      (scl_lvl),
        .sda_lvl      (sda_lvl),
        .scl_rise     (scl_rise),
        .scl_fall     (scl_fall),
        .start_det    (start_det),
        .stop_det     (stop_det),
        .pin_a2       (pin_a2),
        .pin_a1       (pin_a1),
        .wp_i         (wp_i),
        .busy_i       (commit_busy_i),
        .rd_data_i    (rd_data_i),
        .sda_oe       (sda_oe_o),
        .addr_load    (addr_load_o),
        .addr_val     (addr_val_o),
        .rd_inc       (addr_inc_o),
        .wr_strobe    (wr_strobe_o),
        .wr_data      (wr_data_o),
        .commit_start (commit_start_o)
    );

endmodule

// File: tb/eeprom_i2c_target_tb.sv
module eeprom_i2c_target_tb;

    localparam int Q = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic wp = 1'b0;
    logic busy = 1'b0;
    logic [7:0] rd_data;
    logic sda_oe, addr_load, addr_inc, wr_strobe, commit;
    logic [8:0] addr_val;
    logic [7:0] wr_data;
    logic line;

    int checks = 0;
    int fails = 0;
    int commits = 0;
    int wr_cnt = 0;
    logic [8:0] last_load;
    logic [7:0] last_wr;
    logic oe_seen;
    logic done = 1'b0;

    logic [7:0] mem [0:511];
    logic [8:0] ptr;

    always #4 clk = ~clk;

    assign line = sda_m & ~sda_oe;
    assign rd_data = mem[ptr];

    eeprom_i2c_target u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(line),
        .pin_a2(1'b1), .pin_a1(1'b0), .wp_i(wp), .commit_busy_i(busy),
        .rd_data_i(rd_data), .sda_oe_o(sda_oe), .addr_load_o(addr_load),
        .addr_val_o(addr_val), .addr_inc_o(addr_inc), .wr_strobe_o(wr_strobe),
        .wr_data_o(wr_data), .commit_start_o(commit)
    );

    function automatic logic [7:0] orig(input int a);
        return 8'(a) ^ 8'h5A;
    endfunction

    // Environment model: address counter, page buffer and memory.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 512; i++) mem[i] <= orig(i);
            ptr <= '0;
        end else begin
            if (addr_load) begin ptr <= addr_val; last_load <= addr_val; end
            if (addr_inc) ptr <= ptr + 9'd1;
            if (wr_strobe) begin
                mem[ptr] <= wr_data;
                ptr <= {ptr[8:4], ptr[3:0] + 4'd1};
                wr_cnt <= wr_cnt + 1;
                last_wr <= wr_data;
            end
            if (commit) commits <= commits + 1;
            if (sda_oe) oe_seen <= 1'b1;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start;
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q); tick(4);
    endtask

    task automatic clk_bit(input logic b, output logic s);
        sda_m = b; tick(Q); scl_m = 1'b1; tick(Q);
        s = line; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(d[i], s);
        clk_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); d[i] = s; end
        clk_bit(~give_ack, s);
    endtask

    // Device word vectors: {word, busy, expected ack}; straps a2=1, a1=0.
    localparam logic [9:0] DEV_VEC [0:7] = '{
        {8'hA8, 1'b0, 1'b1},
        {8'hAA, 1'b0, 1'b1},
        {8'hAC, 1'b0, 1'b0},
        {8'hA0, 1'b0, 1'b0},
        {8'hB8, 1'b0, 1'b0},
        {8'hE8, 1'b0, 1'b0},
        {8'hA8, 1'b1, 1'b0},
        {8'hA9, 1'b1, 1'b0}
    };

    initial begin
        logic ack;
        logic [7:0] d;
        logic s;
        repeat (6) @(negedge clk);
        check("R3 reset oe", 32'(sda_oe), 0);
        rst_n = 1'b1;
        tick(4);
        check("R3 idle oe", 32'(sda_oe), 0);

        // Addressing and busy poll table (R3, R9).
        for (int i = 0; i < 8; i++) begin
            busy = DEV_VEC[i][1];
            bus_start;
            send_byte(DEV_VEC[i][9:2], ack);
            check($sformatf("R3/R9 devword %0h busy %0d", DEV_VEC[i][9:2], DEV_VEC[i][1]),
                  32'(ack), 32'(DEV_VEC[i][0]));
            bus_stop;
        end
        busy = 1'b0;
        check("R5 no commit without data", commits, 0);

        // Byte write at 0x123 (R4, R5).
        bus_start;
        send_byte(8'hAA, ack); check("R4 dev ack", 32'(ack), 1);
        send_byte(8'h23, ack); check("R4 addr ack", 32'(ack), 1);
        check("R4 addr load", 32'(last_load), 32'h123);
        send_byte(8'h3C, ack); check("R5 data ack", 32'(ack), 1);
        check("R5 data strobe", 32'(last_wr), 32'h3C);
        bus_stop;
        check("R5 commit count", commits, 1);

        // Page write with roll-over inside the page (R5).
        bus_start;
        send_byte(8'hA8, ack);
        send_byte(8'h4E, ack);
        send_byte(8'h11, ack);
        send_byte(8'h22, ack);
        send_byte(8'h33, ack); check("R5 page third ack", 32'(ack), 1);
        bus_stop;
        check("R5 page commit", commits, 2);
        check("R5 page strobes", wr_cnt, 4);

        // Write protect (R6).
        wp = 1'b1;
        bus_start;
        send_byte(8'hA8, ack); check("R6 dev ack", 32'(ack), 1);
        send_byte(8'h50, ack); check("R6 addr ack", 32'(ack), 1);
        send_byte(8'h99, ack); check("R6 data nack", 32'(ack), 0);
        send_byte(8'h98, ack); check("R6 second nack", 32'(ack), 0);
        bus_stop;
        wp = 1'b0;
        check("R6 no commit", commits, 2);
        check("R6 no strobe", wr_cnt, 4);

        // Random read with sequential continuation (R10, R7, R8).
        bus_start;
        send_byte(8'hA8, ack);
        send_byte(8'h4E, ack);
        bus_start;
        send_byte(8'hA9, ack); check("R7 read dev ack", 32'(ack), 1);
        recv_byte(1'b1, d); check("R10 first byte", 32'(d), 32'h11);
        recv_byte(1'b1, d); check("R8 sequential byte", 32'(d), 32'h22);
        recv_byte(1'b0, d); check("R6 protected byte intact", 32'(d), 32'(orig(32'h50)));
        bus_stop;

        // Current-address read continues at 0x51 (R7).
        bus_start;
        send_byte(8'hA9, ack);
        recv_byte(1'b0, d); check("R7 current address", 32'(d), 32'(orig(32'h51)));
        bus_stop;

        // Page roll-over landed at 0x40; byte write landed at 0x123 (R5).
        bus_start;
        send_byte(8'hA8, ack); send_byte(8'h40, ack);
        bus_start;
        send_byte(8'hA9, ack);
        recv_byte(1'b0, d); check("R5 page rollover data", 32'(d), 32'h33);
        bus_stop;
        bus_start;
        send_byte(8'hAA, ack); send_byte(8'h23, ack);
        bus_start;
        send_byte(8'hA9, ack);
        recv_byte(1'b0, d); check("R5 byte write data", 32'(d), 32'h3C);
        bus_stop;

        // Array wrap on sequential read (R8).
        bus_start;
        send_byte(8'hAA, ack); send_byte(8'hFF, ack);
        bus_start;
        send_byte(8'hA9, ack);
        recv_byte(1'b1, d); check("R8 last address", 32'(d), 32'(orig(32'h1FF)));
        recv_byte(1'b0, d); check("R8 wrap to zero", 32'(d), 32'(orig(0)));

        // NACK without stop: line stays released (R8).
        @(negedge clk) oe_seen = 1'b0;
        for (int i = 0; i < 9; i++) clk_bit(1'b1, s);
        check("R8 released after nack", 32'(oe_seen), 0);
        bus_stop;

        // Start in mid-byte restarts reception (R1).
        bus_start;
        for (int i = 0; i < 4; i++) clk_bit(1'b1, s);
        bus_start;
        send_byte(8'hA8, ack); check("R1 restart dev ack", 32'(ack), 1);
        send_byte(8'h10, ack); check("R1 restart addr", 32'(last_load), 32'h010);
        bus_stop;
        check("R1 no commit after abort", commits, 2);

        // Poll acknowledged again once busy is gone (R9).
        busy = 1'b1;
        bus_start; send_byte(8'hA8, ack); check("R9 busy nack", 32'(ack), 0); bus_stop;
        busy = 1'b0;
        bus_start; send_byte(8'hA8, ack); check("R9 ready ack", 32'(ack), 1); bus_stop;

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule